// File: doc/BRIEF.md
# Dual-Channel 22 kHz Tone Source with External Modulation

This block produces the square-wave tone used to signal a satellite low-noise converter on each of two output channels. One shared divider brings a fast clock of about 1.1 MHz down to a tone of about 22 kHz. The default ratio is 50: 25 clocks high and 25 clocks low. Each channel takes the divided tone and drives one tone-drive bit into the analog wave-shaping stage that follows.

Each channel has its own enable and a 2-bit mode. In continuous mode the channel sends the divided tone without a break. In gated mode a per-channel external modulation pin switches that tone on and off. In pass-through mode a waveform that has already been modulated outside the block is copied to the output without change. Each external pin goes through its own two-flop synchronizer before it is used. The channels do not affect each other except that both use the same divider.

Top module: `dual_tone_source`

## Requirements
- R1: While reset is asserted, every tone output is 0. The first clock edge after reset is released starts the high half of the tone period.
- R2: The tone period is 2*HALF_CYCLES clocks (50 by default). The divided tone changes level only at the start of a period and at its midpoint.
- R3: The duty cycle is exactly 50%: HALF_CYCLES clocks high, then HALF_CYCLES clocks low.
- R4: When a channel's enable bit is 0, its output is 0 on the next clock edge, whatever its mode and external input.
- R5: Mode code 0 (continuous): the output follows the divided tone, one clock behind the divider, and the external input has no effect.
- R6: Mode code 1 (gated): the output is the divided tone ANDed with the synchronized external input.
- R7: Mode code 2 (pass-through): the output copies the external input. A level sampled at clock edge k appears at the output after edge k+2 (two synchronizer stages plus the output register).
- R8: Mode code 3 is treated the same as continuous mode.
- R9: Each channel's output depends only on that channel's enable, mode and external input.
- R10: Two channels that are both enabled in continuous mode produce identical, in-phase outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock (about 1.1 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_en | input | NUM_CH | Per-channel enable, bit i for channel i |
| mode_sel | input | 2*NUM_CH | Per-channel mode, bits [2i+1:2i] for channel i: 0 continuous, 1 gated, 2 pass-through, 3 continuous |
| ext_mod | input | NUM_CH | Per-channel external modulation input, asynchronous |
| tone_out | output | NUM_CH | Per-channel tone-drive bit |

## Verification
The assertions check a number of behaviours on every cycle:
- The divider's wrap spacing and that the tone changes level only at the period boundaries.
- That a disabled channel drops to 0.
- That each mode's output matches the divided tone and the synchronized input from the previous cycle.

Other properties can only be shown by the bench's scenarios, measured at the ports:
- The real input-to-output latency through the synchronizer.
- That the external input has no effect in continuous mode.
- That the two channels are independent across every combination of enable and mode.
- That the tone phase after reset is correct.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef enum logic [1:0] {
    TM_CONT = 2'd0,
    TM_GATE = 2'd1,
    TM_PASS = 2'd2,
    TM_ALT  = 2'd3
  } tone_mode_e;

  // Level a channel drives for a given mode, tone phase and synced input.
  function automatic logic chan_level(logic [1:0] m, logic ph, logic ext);
    logic lvl;
    case (tone_mode_e'(m))
      TM_GATE: lvl = ph & ext;
      TM_PASS: lvl = ext;
      default: lvl = ph;
    endcase
    return lvl;
  endfunction

  // High during the first half of the period.
  function automatic logic phase_of(int unsigned cnt, int unsigned half);
    return (cnt < half);
  endfunction
endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int unsigned HALF_CYCLES = 25,
  localparam int unsigned PERIOD = 2 * HALF_CYCLES,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o,
  output logic          phase_o,
  output logic          wrap_o
);
  import tone_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign wrap_o  = (cnt_q == LAST);
  assign phase_o = phase_of(int'(cnt_q), HALF_CYCLES);
endmodule

// File: rtl/mod_sync.sv
module mod_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[b] <= '0;
      else        chain_q[b] <= {chain_q[b][STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[b][STAGES-1];
  end
endmodule

// File: rtl/tone_channel.sv
module tone_channel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       phase_i,
  input  logic       ext_i,
  output logic       out_o
);
  import tone_pkg::*;

  logic level_next;
  assign level_next = en_i ? chan_level(mode_i, phase_i, ext_i) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_o <= 1'b0;
    else        out_o <= level_next;
  end
endmodule

// File: rtl/dual_tone_source.sv
module dual_tone_source #(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned HALF_CYCLES = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   tone_en,
  input  logic [2*NUM_CH-1:0] mode_sel,
  input  logic [NUM_CH-1:0]   ext_mod,
  output logic [NUM_CH-1:0]   tone_out
);
  localparam int unsigned CW = $clog2(2 * HALF_CYCLES);

  logic [CW-1:0]     div_cnt;
  logic              div_phase;
  logic              div_wrap;
  logic [NUM_CH-1:0] ext_sync;

  tone_divider #(.HALF_CYCLES(HALF_CYCLES)) u_div (
    .clk(clk), .rst_n(rst_n),
    .cnt_o(div_cnt), .phase_o(div_phase), .wrap_o(div_wrap)
  );

  mod_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ext_mod), .q_o(ext_sync)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tone_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .en_i(tone_en[c]), .mode_i(mode_sel[2*c +: 2]),
      .phase_i(div_phase), .ext_i(ext_sync[c]),
      .out_o(tone_out[c])
    );
  end
endmodule

// File: rtl/tone_checks.sv
module tone_checks #(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned HALF_CYCLES = 25,
  localparam int unsigned CW = $clog2(2 * HALF_CYCLES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   tone_en,
  input logic [2*NUM_CH-1:0] mode_sel,
  input logic [NUM_CH-1:0]   tone_out,
  input logic [CW-1:0]       div_cnt,
  input logic                div_phase,
  input logic                div_wrap,
  input logic [NUM_CH-1:0]   ext_sync
);
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= '0;
    else if (div_wrap) gap_q <= '0;
    else               gap_q <= gap_q + 1'b1;
  end

  // R2: wraps are one full period apart
  assert_wrap_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_wrap |-> (gap_q == CW'(2 * HALF_CYCLES - 1)));

  // R3: the tone changes level only at a period start or its midpoint
  assert_phase_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_phase != $past(div_phase)) |-> (div_cnt == '0 || div_cnt == CW'(HALF_CYCLES)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_off_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_en[c] |=> !tone_out[c]);
    assert_cont_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_en[c] && mode_sel[2*c +: 2] == 2'd0) |=> (tone_out[c] == $past(div_phase)));
    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_en[c] && mode_sel[2*c +: 2] == 2'd1) |=>
        (tone_out[c] == ($past(div_phase) & $past(ext_sync[c]))));
    assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_en[c] && mode_sel[2*c +: 2] == 2'd2) |=> (tone_out[c] == $past(ext_sync[c])));
    assert_alt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_en[c] && mode_sel[2*c +: 2] == 2'd3) |=> (tone_out[c] == $past(div_phase)));
  end
endmodule

bind dual_tone_source tone_checks #(.NUM_CH(NUM_CH), .HALF_CYCLES(HALF_CYCLES)) u_tone_checks (
  .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .mode_sel(mode_sel),
  .tone_out(tone_out), .div_cnt(div_cnt), .div_phase(div_phase),
  .div_wrap(div_wrap), .ext_sync(ext_sync)
);

// File: tb/test_dual_tone_source.sv
module test_dual_tone_source;
  localparam int NCH  = 2;
  localparam int HALF = 25;
  localparam int PER  = 2 * HALF;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] tone_en = '0;
  logic [2*NCH-1:0] mode_sel = '0;
  logic [NCH-1:0] ext_mod = '0;
  logic [NCH-1:0] tone_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_tone_source #(.NUM_CH(NCH), .HALF_CYCLES(HALF)) i_dual_tone_source (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .mode_sel(mode_sel),
    .ext_mod(ext_mod), .tone_out(tone_out)
  );

  // Reference: edges since reset, input history, expected output register.
  int unsigned    edge_n;
  logic [NCH-1:0] e1, e2, exp_out;

  function automatic logic want(logic en, logic [1:0] m, int unsigned n, logic e);
    logic hi;
    hi = ((n % PER) < HALF);
    if (!en) return 1'b0;
    if (m == 2'd2) return e;
    return hi & ((m == 2'd1) ? e : 1'b1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_n <= 0; e1 <= '0; e2 <= '0; exp_out <= '0;
    end else begin
      edge_n <= edge_n + 1;
      e1 <= ext_mod;
      e2 <= e1;
      for (int c = 0; c < NCH; c++)
        exp_out[c] <= want(tone_en[c], mode_sel[2*c +: 2], edge_n, e2[c]);
    end
  end

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  function automatic string req_of(logic en, logic [1:0] m);
    if (!en) return "R4";
    case (m)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    int hi_cnt;
    int last_rise;
    int rise_gap;
    logic prev;
    // R1: outputs low in reset even with everything enabled
    tone_en = '1; ext_mod = '1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R1", tone_out[c], 1'b0);
    rst_n = 1'b1;
    // R1: first two edges after release give high tone (continuous mode)
    @(negedge clk); check("R1", tone_out[0], 1'b1);

    // R2 R3 R10: measure the tone at the port in continuous mode
    hi_cnt = 0; last_rise = -1; rise_gap = 0; prev = tone_out[0];
    for (int k = 0; k < 4 * PER; k++) begin
      @(negedge clk);
      if (k >= 2 * PER) hi_cnt += tone_out[0];
      if (tone_out[0] && !prev) begin
        if (last_rise >= 0) rise_gap = k - last_rise;
        last_rise = k;
      end
      prev = tone_out[0];
      check("R10", tone_out[1], tone_out[0]);
    end
    check("R2", rise_gap == PER, 1'b1);
    check("R3", hi_cnt == 2 * HALF, 1'b1);

    // R7: pass-through latency is exactly three edges
    mode_sel = {2'd2, 2'd2}; ext_mod = '0;
    repeat (4) @(negedge clk);
    ext_mod = 2'b11;
    @(negedge clk); check("R7", tone_out[0], 1'b0);
    @(negedge clk); check("R7", tone_out[0], 1'b0);
    @(negedge clk); check("R7", tone_out[0], 1'b1);

    // R9 sweep: every enable and mode pair with several input patterns
    for (int cfg = 0; cfg < 64; cfg++) begin
      for (int pat = 0; pat < 3; pat++) begin
        tone_en  = cfg[1:0];
        mode_sel = cfg[5:2];
        for (int k = 0; k < 60; k++) begin
          case (pat)
            0: ext_mod = 2'b00;
            1: ext_mod = 2'b11;
            default: ext_mod = {((k % 11) < 5) ? 1'b1 : 1'b0, ((k / 3) % 2 == 1) ? 1'b1 : 1'b0};
          endcase
          @(negedge clk);
          for (int c = 0; c < NCH; c++)
            check(req_of(tone_en[c], mode_sel[2*c +: 2]), tone_out[c], exp_out[c]);
        end
      end
    end

    // R4: disable takes effect at the next edge
    tone_en = 2'b11; mode_sel = '0;
    while (!(exp_out[0] === 1'b1)) @(negedge clk);
    tone_en = 2'b00; ext_mod = '1;
    @(negedge clk);
    check("R4", tone_out[0], 1'b0);
    check("R4", tone_out[1], 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule